// File: doc/BRIEF.md
# Transmit-Only SPI Slave Channel

This block is a single SPI slave channel for a system that only needs to send data to an external master. Words written by the host go into a transmit store. The store is either a one-word buffer or a small FIFO. The block shifts each word out MSB first on MISO while chip select is low. The serial clock, chip select and MOSI are brought into the system clock domain through two-flop synchronisers. The block acts on edges of the synchronised serial clock using SPI mode 0: it changes MISO after a falling edge, and the master samples on the rising edge.

A 2-bit mode field picks the channel behaviour. With code 2'b10 the channel is transmit-only. In that mode the receive side is silent: no receive word is kept, and no receive-full or receive-overflow event can occur. In every other code the word shifted in on MOSI is captured. The host reaches a small four-word register space through a write strobe, an address and data, and reads it back combinationally. Four write-1-to-clear event bits are masked by enable bits to drive one interrupt line.

Top module: `spi_txo_top`

## Requirements
- R1: After reset the config word reads 0x38 (mode 2'b00, FIFO off, word-length field 7). Status reads 0, irq_o is 0 and miso_o is 0.
- R2: Config bits [1:0] hold the mode. With mode 2'b10 a completed word never sets status bit 2 (receive full) or bit 3 (receive overflow), whatever arrives on MOSI.
- R3: With any other mode, a completed word stores the MOSI bits, which read back at address 1, and sets status bit 2. A further word arriving while bit 2 is still set also sets status bit 3.
- R4: One bit leaves per serial clock, MSB first, and is valid at the rising edge. The word length is config bits [7:3] plus one. Field values below 3 give 4-bit words.
- R5: A word loads from the store when chip select falls and on the falling edge that follows a completed word. An empty store loads all zeros.
- R6: With the FIFO off (config bit 2 = 0), status bit 0 (end of transfer) sets when a word completes.
- R7: With the FIFO on, status bit 0 never sets.
- R8: A write to address 1 pushes a transmit word. The store holds 1 word with the FIFO off, DEPTH words with the FIFO on in mode 2'b10, and DEPTH/2 words with the FIFO on in other modes. Pushes beyond that are dropped.
- R9: Status bit 1 (transmit empty) sets when a load takes the last stored word. If a push lands in the same cycle as that load, the bit does not set and the pushed word is sent next.
- R10: Writing address 2 clears each status bit whose data bit is 1 and leaves the others as they are.
- R11: irq_o is the OR of the status bits ANDed with the enable bits at address 3. Clearing an enable drops irq_o while the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 config, 1 data, 2 status, 3 irq enable) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sclk_i | input | 1 | SPI serial clock from the master |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from the master |
| miso_o | output | 1 | SPI data to the master |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Two things can happen in the same system clock cycle: a host push into the full one-word buffer, and the buffer load triggered by chip select falling. The bench drops chip select and times the data-register write to land on exactly the clock edge where the synchronised falling edge causes the load. It then judges the outcome in three ways: the transmit-empty bit must still read 0, the first word on MISO must be the old one, and the second word must be the one just pushed.

// File: rtl/spi_txo_pkg.sv
package spi_txo_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_IEN  = 2'd3;

  localparam logic [1:0] MODE_TXO  = 2'b10;

  localparam int NUM_EV = 4;
  localparam int EV_EOT = 0;
  localparam int EV_TXE = 1;
  localparam int EV_RXF = 2;
  localparam int EV_OVF = 3;
endpackage

// File: rtl/spi_txo_sync.sv
module spi_txo_sync #(
  parameter int          N   = 1,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST[g];
        sync_q <= RST[g];
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
      end
    end
    assign sync_o[g] = sync_q;
  end
endmodule

// File: rtl/spi_txo_fifo.sv
module spi_txo_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            pop_i,
  input  logic [CNTW-1:0] cap_i,
  output logic [DW-1:0]   rdata_o,
  output logic [CNTW-1:0] cnt_o,
  output logic            empty_ev_o
);
  logic [DW-1:0]   mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;
  logic            pop_ok, push_ok;

  assign pop_ok     = pop_i && (cnt_q != '0);
  assign push_ok    = push_i && ((cnt_q < cap_i) || pop_ok);
  assign empty_ev_o = pop_ok && !push_ok && (cnt_q == CNTW'(1));
  assign rdata_o    = mem_q[rd_q];
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= wdata_i;
        wr_q        <= wr_q + 1'b1;
      end
      if (pop_ok) rd_q <= rd_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/spi_txo_shifter.sv
module spi_txo_shifter #(
  parameter int DW  = 32,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          cs_fall_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          mosi_i,
  input  logic [CW-1:0] wlen_m1_i,
  input  logic [DW-1:0] tx_word_i,
  input  logic          tx_valid_i,
  output logic          pop_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o,
  output logic          miso_o
);
  localparam logic [CW-1:0] TOP  = CW'(DW - 1);
  localparam logic [CW-1:0] LMIN = CW'(3);

  logic [DW-1:0] sr_q, rsr_q, rx_q;
  logic [CW-1:0] bit_q, lw;
  logic          pend_q, fresh_q, done_q, load;
  logic [DW-1:0] mask;

  assign lw     = (wlen_m1_i < LMIN) ? LMIN : wlen_m1_i;
  assign mask   = {DW{1'b1}} >> (TOP - lw);
  // keep an untouched real word across a chip-select gap
  assign load   = (cs_fall_i && !fresh_q) || (cs_act_i && sclk_fall_i && pend_q);
  assign pop_o  = load;
  assign done_o = done_q;
  assign rx_word_o = rx_q;
  assign miso_o = sr_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      rsr_q   <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      pend_q  <= 1'b0;
      fresh_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!cs_act_i) begin
        bit_q  <= '0;
        pend_q <= 1'b0;
      end else if (sclk_rise_i) begin
        rsr_q   <= {rsr_q[DW-2:0], mosi_i};
        fresh_q <= 1'b0;
        if (bit_q == lw) begin
          bit_q  <= '0;
          pend_q <= 1'b1;
          done_q <= 1'b1;
          rx_q   <= {rsr_q[DW-2:0], mosi_i} & mask;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
      if (load) begin
        sr_q    <= tx_valid_i ? (tx_word_i << (TOP - lw)) : '0;
        fresh_q <= tx_valid_i;
        pend_q  <= 1'b0;
      end else if (cs_act_i && sclk_fall_i) begin
        sr_q <= sr_q << 1;
      end
    end
  end
endmodule

// File: rtl/spi_txo_top.sv
module spi_txo_top
  import spi_txo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DW),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        sclk_i,
  input  logic        cs_ni,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        irq_o
);
  logic [1:0]        mode_q;
  logic              fifo_en_q;
  logic [CW-1:0]     wlen_q;
  logic [NUM_EV-1:0] stat_q, ien_q, ev_set, ev_clr;

  logic [2:0] sync;
  logic       sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic       sclk_rise, sclk_fall, cs_fall;

  logic [DW-1:0]   tx_word, rx_word;
  logic [CNTW-1:0] cnt, cap;
  logic            pop, done, empty_ev, push;

  spi_txo_sync #(.N(3), .RST(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .async_i({mosi_i, cs_ni, sclk_i}),
    .sync_o (sync)
  );
  assign {mosi_s, cs_s, sclk_s} = sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end
  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;
  assign cs_fall   = !cs_s && cs_d;

  assign push = reg_we_i && (reg_addr_i == ADDR_DATA);
  assign cap  = !fifo_en_q ? CNTW'(1)
              : (mode_q == MODE_TXO) ? CNTW'(DEPTH) : CNTW'(DEPTH / 2);

  spi_txo_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i    (push),
    .wdata_i   (reg_wdata_i[DW-1:0]),
    .pop_i     (pop),
    .cap_i     (cap),
    .rdata_o   (tx_word),
    .cnt_o     (cnt),
    .empty_ev_o(empty_ev)
  );

  spi_txo_shifter #(.DW(DW)) u_shift (
    .clk_i, .rst_ni,
    .cs_act_i   (!cs_s),
    .cs_fall_i  (cs_fall),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .mosi_i     (mosi_s),
    .wlen_m1_i  (wlen_q),
    .tx_word_i  (tx_word),
    .tx_valid_i (cnt != '0),
    .pop_o      (pop),
    .done_o     (done),
    .rx_word_o  (rx_word),
    .miso_o     (miso_o)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_EOT] = done && !fifo_en_q;
    ev_set[EV_TXE] = empty_ev;
    ev_set[EV_RXF] = done && (mode_q != MODE_TXO);
    ev_set[EV_OVF] = done && (mode_q != MODE_TXO) && stat_q[EV_RXF];
    ev_clr = (reg_we_i && reg_addr_i == ADDR_STAT) ? reg_wdata_i[NUM_EV-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 2'b00;
      fifo_en_q <= 1'b0;
      wlen_q    <= CW'(7);
      ien_q     <= '0;
      stat_q    <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == ADDR_CFG) begin
        mode_q    <= reg_wdata_i[1:0];
        fifo_en_q <= reg_wdata_i[2];
        wlen_q    <= reg_wdata_i[3 +: CW];
      end
      if (reg_we_i && reg_addr_i == ADDR_IEN) ien_q <= reg_wdata_i[NUM_EV-1:0];
      stat_q <= (stat_q & ~ev_clr) | ev_set; // set beats clear
    end
  end

  assign irq_o = |(stat_q & ien_q);

  always_comb begin
    case (reg_addr_i)
      ADDR_CFG:  reg_rdata_o = 32'({wlen_q, fifo_en_q, mode_q});
      ADDR_DATA: reg_rdata_o = 32'(rx_word);
      ADDR_STAT: reg_rdata_o = 32'(stat_q);
      default:   reg_rdata_o = 32'(ien_q);
    endcase
  end
endmodule

// File: rtl/spi_txo_chk.sv
module spi_txo_chk #(
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_q,
  input logic            fifo_en_q,
  input logic [3:0]      stat_q,
  input logic            done,
  input logic [CNTW-1:0] cnt,
  input logic            sclk_fall,
  input logic            cs_fall,
  input logic            miso_o
);
  assert_txo_no_rx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && mode_q == 2'b10) |=> (!$rose(stat_q[2]) && !$rose(stat_q[3])));

  assert_miso_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miso_o) |-> $past(sclk_fall || cs_fall));

  assert_eot_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !fifo_en_q) |=> stat_q[0]);

  assert_eot_fifo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[0]) |-> !$past(fifo_en_q));

  assert_fill_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNTW'(DEPTH));

  assert_txe_when_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[1]) |-> (cnt == '0));
endmodule

bind spi_txo_top spi_txo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_q(mode_q), .fifo_en_q(fifo_en_q),
  .stat_q(stat_q), .done(done), .cnt(cnt), .sclk_fall(sclk_fall),
  .cs_fall(cs_fall), .miso_o(miso_o)
);

// File: tb/tb_spi_txo_top.sv
`timescale 1ns/1ps
module tb_spi_txo_top;
  localparam int H = 6;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, irq;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  spi_txo_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sclk_i(sclk),
    .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso), .irq_o(irq)
  );

  // {mode[1:0], wlen field[4:0], word[31:0]}
  localparam logic [38:0] VEC [6] = '{
    {2'b10, 5'd7,  32'h0000_00A5},
    {2'b10, 5'd15, 32'h0000_1234},
    {2'b10, 5'd31, 32'hDEAD_BEEF},
    {2'b00, 5'd11, 32'h0000_05C3},
    {2'b10, 5'd4,  32'h0000_0016},
    {2'b01, 5'd7,  32'h0000_003C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (H) @(negedge clk); cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic spi_word(input int wl, input logic [31:0] mo, output logic [31:0] mi);
    mi = '0;
    for (int i = wl - 1; i >= 0; i--) begin
      mosi = mo[i];
      repeat (H) @(negedge clk);
      mi = {mi[30:0], miso};
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  function automatic logic [31:0] wmask(input int wl);
    return (wl >= 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, mi;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1 chk("R1 miso", 32'(miso), 0);
    chk("R1 irq", 32'(irq), 0);
    reg_rd(2'd0, d); chk("R1 cfg", d, 32'h38);
    reg_rd(2'd2, d); chk("R1 status", d, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R2 R3 R4 R6
    for (int v = 0; v < 6; v++) begin
      logic [1:0]  md;
      logic [4:0]  wf;
      logic [31:0] w;
      int          wl;
      {md, wf, w} = VEC[v];
      wl = int'(wf) + 1;
      reg_wr(2'd0, {24'd0, wf, 1'b0, md});
      reg_wr(2'd2, 32'hF);
      reg_wr(2'd1, w);
      cs_lo();
      spi_word(wl, ~w, mi);
      cs_hi();
      chk("R4 shifted word", mi, w & wmask(wl));
      reg_rd(2'd2, d);
      chk("R6 eot", 32'(d[0]), 1);
      if (md == 2'b10) chk("R2 no rx events", 32'(d[3:2]), 0);
      else begin
        chk("R3 rx full", 32'(d[3:2]), 32'b01);
        reg_rd(2'd1, d); chk("R3 rx word", d, ~w & wmask(wl));
      end
    end

    // R3 overflow on second word with rx full pending
    reg_wr(2'd0, {24'd0, 5'd7, 1'b0, 2'b00});
    reg_wr(2'd2, 32'hF);
    cs_lo(); spi_word(8, 32'h5A, mi); spi_word(8, 32'hC3, mi); cs_hi();
    reg_rd(2'd2, d); chk("R3 overflow", 32'(d[3:2]), 32'b11);
    reg_rd(2'd1, d); chk("R3 latest rx", d, 32'hC3);

    // R4 clamp: field 1 gives 4-bit words; R5 empty gives zeros
    reg_wr(2'd0, {24'd0, 5'd1, 1'b0, 2'b10});
    reg_wr(2'd1, 32'hB);
    cs_lo(); spi_word(4, 0, mi); chk("R4 clamp word", mi, 32'hB);
    spi_word(4, 0, mi); chk("R5 empty zeros", mi, 0); cs_hi();

    // R8 capacity with FIFO on, tx-only: DEPTH=4
    reg_wr(2'd0, {24'd0, 5'd7, 1'b1, 2'b10});
    reg_wr(2'd2, 32'hF);
    for (int i = 0; i < 6; i++) reg_wr(2'd1, 32'h11 + i);
    cs_lo();
    for (int i = 0; i < 6; i++) begin
      spi_word(8, 0, mi);
      chk("R8 tx-only fifo", mi, (i < 4) ? 32'h11 + i : 0);
    end
    cs_hi();
    reg_rd(2'd2, d); chk("R7 eot stays low", 32'(d[0]), 0);

    // R8 capacity with FIFO on, other mode: DEPTH/2
    reg_wr(2'd0, {24'd0, 5'd7, 1'b1, 2'b00});
    for (int i = 0; i < 3; i++) reg_wr(2'd1, 32'h21 + i);
    cs_lo();
    for (int i = 0; i < 3; i++) begin
      spi_word(8, 0, mi);
      chk("R8 half fifo", mi, (i < 2) ? 32'h21 + i : 0);
    end
    cs_hi();

    // R8 single buffer with FIFO off
    reg_wr(2'd0, {24'd0, 5'd7, 1'b0, 2'b10});
    reg_wr(2'd1, 32'h31); reg_wr(2'd1, 32'h32);
    cs_lo(); spi_word(8, 0, mi); chk("R8 single buffer", mi, 32'h31);
    spi_word(8, 0, mi); chk("R8 dropped push", mi, 0); cs_hi();

    // R9 push lands on the load edge
    reg_wr(2'd1, 32'h41);
    reg_wr(2'd2, 32'hF);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    reg_wr(2'd1, 32'h42);
    reg_rd(2'd2, d); chk("R9 no empty on collision", 32'(d[1]), 0);
    repeat (H) @(negedge clk);
    spi_word(8, 0, mi); chk("R9 old word first", mi, 32'h41);
    spi_word(8, 0, mi); chk("R9 pushed word next", mi, 32'h42);
    cs_hi();
    reg_rd(2'd2, d); chk("R9 empty after last", 32'(d[1]), 1);

    // R10 selective clear
    reg_rd(2'd2, d); chk("R10 pre-clear", d & 32'h3, 32'h3);
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, d); chk("R10 w1c", d & 32'h3, 32'h2);

    // R11 masking
    reg_wr(2'd3, 32'h2);
    #1 chk("R11 irq on", 32'(irq), 1);
    reg_wr(2'd3, 32'h0);
    #1 chk("R11 irq masked", 32'(irq), 0);
    reg_rd(2'd2, d); chk("R11 status kept", 32'(d[1]), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule